// File: doc/BRIEF.md
# Card Socket Hotplug Debouncer

This block watches the detect and write-protect contacts of a removable card socket and turns the noisy detect contact into clean hotplug events. The detect contact is active low: a low level means a card sits in the socket. Both contacts pass through a two-flop synchronizer. Each qualifying change of the synchronized detect level restarts a one-shot settling timer. The detect level is looked at only once, when that timer runs out. The block then emits a single-cycle insert pulse if the level is low, or a single-cycle remove pulse if it is high.

A mode input picks which changes count. With the mode low, both a card going in and a card coming out restart the timer. With the mode high, only the high-to-low change arms it. The block also keeps a registered presence flag, which is updated at every event. It keeps a "card ready" flag as well: an identification-complete strobe sets it, and every event clears it so that the card must be identified again.

Top module: `card_hotplug_debounce`

## Requirements
- R1: While reset is held and right after it, the insert pulse, remove pulse, presence flag, ready flag and write-protect output are all low.
- R2: The settling time is SETTLE_CYC clock cycles. Suppose det_n_raw changes just after rising edge N and then stays quiet. The resulting event output is high for exactly the one cycle that follows rising edge N+SETTLE_CYC+3.
- R3: At expiry, a low synchronized detect level produces a pulse on evt_insert and a high level produces a pulse on evt_remove. Each pulse lasts one cycle.
- R4: A qualifying change that arrives while the timer runs restarts the full settling time. One expiry gives at most one event.
- R5: When insert_only is 1, a low-to-high detect change neither arms nor restarts the timer. A short low glitch therefore ends in a remove event, timed from its falling edge.
- R6: An event fires at expiry even when the sampled level matches the state reported last time.
- R7: card_present becomes 1 with every insert event and 0 with every remove event, and it holds its value in all other cycles.
- R8: An ident_done pulse sets card_ready one cycle later. Every event clears card_ready, and the clear wins when both happen in the same cycle.
- R9: write_protect equals wp_raw delayed by two rising edges. It does not depend on the detect path.
- R10: evt_insert and evt_remove are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_n_raw | input | 1 | Raw socket detect contact, low = card present |
| wp_raw | input | 1 | Raw write-protect contact |
| insert_only | input | 1 | 1: only falling detect edges arm the timer |
| ident_done | input | 1 | Pulse: card identification finished |
| evt_insert | output | 1 | One-cycle insertion event |
| evt_remove | output | 1 | One-cycle extraction event |
| card_present | output | 1 | Level reported by the most recent event |
| card_ready | output | 1 | Card identified since the last event |
| write_protect | output | 1 | Synchronized write-protect level |

## Verification
An event is due three cycles plus the settling time after the last qualifying detect change: two synchronizer flops, the timer load, and the event register. The driver stamps every expected event with that absolute cycle number and pushes it into a queue. The monitor samples on the falling clock edge. It flags an event that comes early or late, one that was not expected, or one that never arrives. The write-protect lag of two edges and the ready flag one cycle after ident_done are checked at those exact falling edges.

// File: rtl/hotplug_pkg.sv
package hotplug_pkg;

    typedef struct packed {
        logic armed;
        logic [31:0] cnt;
    } timer_state_t;

    typedef struct packed {
        logic det_prev;
        logic ins;
        logic rem;
        logic present;
        logic ready;
    } event_state_t;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/hp_settle_timer.sv
module hp_settle_timer #(
    parameter int SETTLE_CYC = 15_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    import hotplug_pkg::*;
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [31:0] LOAD = 32'(SETTLE_CYC - 1);

    timer_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (restart) begin
            st_d.armed = 1'b1;
            st_d.cnt   = LOAD;
        end else if (st_q.armed) begin
            if (st_q.cnt == '0) begin
                expire     = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 32'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the count never exceeds the load value while armed
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.cnt <= LOAD));
    // R4: a restart always leaves the timer armed at full length
    a_r4_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.armed && st_q.cnt == LOAD));
    // R4: at most one expiry per arming
    a_r4_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !st_q.armed || $past(restart));

    logic unused_w;
    assign unused_w = ^CNT_W;
endmodule

// File: rtl/card_hotplug_debounce.sv
module card_hotplug_debounce #(
    parameter int SETTLE_CYC = 15_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_n_raw,
    input  logic wp_raw,
    input  logic insert_only,
    input  logic ident_done,
    output logic evt_insert,
    output logic evt_remove,
    output logic card_present,
    output logic card_ready,
    output logic write_protect
);
    import hotplug_pkg::*;

    logic [1:0] sync_out;
    logic       det_s;
    logic       edge_fall, edge_rise, arm, expire;

    event_state_t ev_d, ev_q;

    hp_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wp_raw, det_n_raw}),
        .dout (sync_out)
    );
    assign det_s         = sync_out[0];
    assign write_protect = sync_out[1];

    assign edge_fall = ev_q.det_prev & ~det_s;
    assign edge_rise = ~ev_q.det_prev & det_s;
    assign arm       = edge_fall | (edge_rise & ~insert_only);

    hp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(arm),
        .expire (expire)
    );

    always_comb begin
        ev_d          = ev_q;
        ev_d.det_prev = det_s;
        ev_d.ins      = 1'b0;
        ev_d.rem      = 1'b0;
        if (ident_done) ev_d.ready = 1'b1;
        if (expire) begin
            ev_d.ins     = ~det_s;
            ev_d.rem     = det_s;
            ev_d.present = ~det_s;
            ev_d.ready   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '{det_prev: 1'b1, ins: 1'b0, rem: 1'b0, present: 1'b0, ready: 1'b0};
        else        ev_q <= ev_d;
    end

    assign evt_insert   = ev_q.ins;
    assign evt_remove   = ev_q.rem;
    assign card_present = ev_q.present;
    assign card_ready   = ev_q.ready;

    // R10: never both events together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_insert, evt_remove}));
    // R3: events last a single cycle
    a_r3_ins_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_insert |=> !evt_insert);
    a_r3_rem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_remove |=> !evt_remove);
    // R7: presence agrees with the event and holds otherwise
    a_r7_ins_present: assert property (@(posedge clk) disable iff (!rst_n)
        evt_insert |-> card_present);
    a_r7_rem_absent: assert property (@(posedge clk) disable iff (!rst_n)
        evt_remove |-> !card_present);
    a_r7_present_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_insert || evt_remove) |-> $stable(card_present));
    // R8: every event leaves the ready flag cleared
    a_r8_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_insert || evt_remove) |-> !card_ready);
endmodule

// File: tb/tb_card_hotplug_debounce.sv
module tb_card_hotplug_debounce;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_n_raw = 1'b1;
    logic wp_raw = 1'b0;
    logic insert_only = 1'b0;
    logic ident_done = 1'b0;
    logic evt_insert, evt_remove, card_present, card_ready, write_protect;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct { int at; bit ins; string req; } exp_t;
    exp_t q[$];

    card_hotplug_debounce #(.SETTLE_CYC(T)) dut (
        .clk(clk), .rst_n(rst_n), .det_n_raw(det_n_raw), .wp_raw(wp_raw),
        .insert_only(insert_only), .ident_done(ident_done),
        .evt_insert(evt_insert), .evt_remove(evt_remove),
        .card_present(card_present), .card_ready(card_ready),
        .write_protect(write_protect)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: change detect level now; optionally schedule an event
    task automatic drive_det(logic v);
        det_n_raw = v;
    endtask

    task automatic expect_evt(int base, bit ins, string req);
        exp_t e;
        e.at = base + T + 3; e.ins = ins; e.req = req;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() != 0 && q[0].at < cyc) begin
                total++; bad++;
                $display("FAIL %s missing event: actual=none expected=%0s at cycle %0d",
                         q[0].req, q[0].ins ? "insert" : "remove", q[0].at);
                void'(q.pop_front());
            end
            if (evt_insert && evt_remove) begin
                total++; bad++;
                $display("FAIL R10 both events: actual=11 expected=one-hot at cycle %0d", cyc);
            end
            if (evt_insert || evt_remove) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R2 unexpected event: actual=%0b%0b expected=none at cycle %0d",
                             evt_insert, evt_remove, cyc);
                end else begin
                    if (q[0].at != cyc || q[0].ins != evt_insert) begin
                        bad++;
                        $display("FAIL %s event: actual=%0s@%0d expected=%0s@%0d", q[0].req,
                                 evt_insert ? "insert" : "remove", cyc,
                                 q[0].ins ? "insert" : "remove", q[0].at);
                    end
                    void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        while (!finished && cyc < 5000) @(negedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        wait_n(3);
        // R1: reset state
        chk("R1", evt_insert, 1'b0, "insert");
        chk("R1", evt_remove, 1'b0, "remove");
        chk("R1", card_present, 1'b0, "present");
        chk("R1", card_ready, 1'b0, "ready");
        chk("R1", write_protect, 1'b0, "wp");
        rst_n = 1'b1;
        wait_n(3);

        // R2/R3: clean insertion
        n = cyc; drive_det(1'b0); expect_evt(n, 1'b1, "R2");
        wait_n(T + 5);
        chk("R7", card_present, 1'b1, "present after insert");

        // R8: ident sets ready one cycle later
        ident_done = 1'b1; wait_n(1); ident_done = 1'b0;
        chk("R8", card_ready, 1'b1, "ready after ident");

        // R3/R8: removal with ident_done coinciding with event register edge
        n = cyc; drive_det(1'b1); expect_evt(n, 1'b0, "R3");
        wait_n(T + 2);
        ident_done = 1'b1; wait_n(1); ident_done = 1'b0;
        chk("R8", card_ready, 1'b0, "clear wins over ident");
        chk("R7", card_present, 1'b0, "present after remove");
        wait_n(3);

        // R4: bouncing insertion restarts timer, single event
        drive_det(1'b0); wait_n(5);
        drive_det(1'b1); wait_n(5);
        n = cyc; drive_det(1'b0); expect_evt(n, 1'b1, "R4");
        wait_n(T + 6);
        chk("R4", card_present, 1'b1, "present after bounce");

        // R6: short high glitch while present gives insert again
        drive_det(1'b1); wait_n(3);
        n = cyc; drive_det(1'b0); expect_evt(n, 1'b1, "R6");
        wait_n(T + 6);
        chk("R6", card_present, 1'b1, "present after repeat insert");

        // R5: insertion-only mode ignores removal
        insert_only = 1'b1;
        drive_det(1'b1); wait_n(2 * T + 6);
        chk("R5", card_present, 1'b1, "present held, rise ignored");
        // R5: low glitch, rising edge does not restart, ends in remove
        n = cyc; drive_det(1'b0); expect_evt(n, 1'b0, "R5");
        wait_n(4); drive_det(1'b1);
        wait_n(T + 4);
        chk("R5", card_present, 1'b0, "present after glitch");
        insert_only = 1'b0;

        // R9: write-protect lag of two edges
        wp_raw = 1'b1; wait_n(1);
        chk("R9", write_protect, 1'b0, "wp after one edge");
        wait_n(1);
        chk("R9", write_protect, 1'b1, "wp after two edges");
        wp_raw = 1'b0; wait_n(2);
        chk("R9", write_protect, 1'b0, "wp low after two edges");
        chk("R9", card_present, 1'b0, "detect path untouched by wp");

        wait_n(T + 6);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R2 pending events: actual=%0d expected=0", q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule